// File: doc/BRIEF.md
# Linked-Slot Packet Buffer Manager

This block stores packets as chains of fixed-size slots and hands the rest of the chip a compact descriptor in place of the packet. On ingress it takes a byte stream. Each packet takes a head slot from an on-chip pool and any further slots from a second pool meant for slower external storage. Slots are joined through a pointer kept in the final word of each slot, and a zero pointer closes the chain. Once the last byte is in, the block emits a 128-bit descriptor.

On egress a descriptor is presented. The block walks the chain, replays exactly the stored bytes with an end-of-packet marker, and returns each slot to its pool as soon as that slot has been read.

Either pool can run dry. When the pool a packet needs is empty, the whole packet is discarded and a drop counter is incremented. Any slots the discarded packet had already taken are handed back.

Top module: `slot_buffer_mgr`

## Requirements
- R1: After reset in_ready and eg_ready are 1, desc_valid and out_valid are 0, drop_count is 0, and both slot pools are full.
- R2: Every stored packet produces exactly one descriptor, valid for a single cycle. Its fields are: bits 15:0 hold the head slot address, bits 31:16 the packet length in bytes, bits 39:32 the tag sampled with the first byte, and bits 127:40 are zero.
- R3: Slot addresses are numbered 1..N_LOC for the on-chip pool and N_LOC+1..N_LOC+N_EXT for the external pool; 0 is the null pointer. A head slot always comes from the on-chip pool and every further slot from the external pool, and no two live packets share a head.
- R4: For an accepted descriptor, egress outputs exactly the packet-length number of bytes, in arrival order, with out_last high on the final byte only.
- R5: Ingress holds in_ready low for exactly one cycle after each slot it closes: once after every SLOT_WORDS-1 bytes when more bytes follow, and once after the last byte of the packet.
- R6: If the on-chip pool is empty at the first byte, the packet's bytes are consumed, no descriptor is produced and drop_count rises by 1.
- R7: If the external pool is empty when a packet needs another slot, the remaining bytes are consumed, no descriptor is produced and drop_count rises by 1. All slots that packet had taken are returned.
- R8: Slots read out by egress are returned to their pools and can be allocated to later packets.
- R9: eg_ready is low while a chain is being read out, and a descriptor presented during that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Ingress byte valid |
| in_data | input | 8 | Ingress byte |
| in_last | input | 1 | Marks the last byte of a packet |
| in_tag | input | 8 | Packet tag, sampled with the first byte |
| in_ready | output | 1 | Ingress can take a byte this cycle |
| desc_valid | output | 1 | Descriptor output valid (one cycle) |
| desc_data | output | 128 | Descriptor of a stored packet |
| drop_count | output | 16 | Number of discarded packets |
| eg_desc_valid | input | 1 | Egress descriptor valid |
| eg_desc | input | 128 | Descriptor of the packet to read out |
| eg_ready | output | 1 | Egress idle and able to take a descriptor |
| out_valid | output | 1 | Egress byte valid |
| out_data | output | 8 | Egress byte |
| out_last | output | 1 | Final byte of the packet |

## Verification
The bench builds the block with four-word slots (three data bytes each), four on-chip slots and six external slots. With these values a 21-byte packet exactly fills the external pool and a 22-byte packet runs it dry partway through. Five short packets outrun the on-chip pool. A random mix of sends and out-of-order reads therefore exhausts and refills both pools many times. The bench tracks the free count of each pool to predict every drop.

// File: rtl/slot_buf_pkg.sv
package slot_buf_pkg;
  localparam int DESC_W   = 128;
  localparam int HEAD_LSB = 0;
  localparam int HEAD_W   = 16;
  localparam int LEN_LSB  = 16;
  localparam int LEN_W    = 16;
  localparam int TAG_LSB  = 32;
  localparam int TAG_W    = 8;
  localparam int DROP_W   = 16;

  typedef enum logic [1:0] {IS_IDLE, IS_DATA, IS_LINK, IS_DROP} ing_st_t;
  typedef enum logic [1:0] {ES_IDLE, ES_RD, ES_PTR, ES_WAIT} egr_st_t;
endpackage

// File: rtl/slot_free_list.sv
module slot_free_list #(
  parameter int DEPTH  = 8,
  parameter int BASE   = 1,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pop,
  output logic [SLOT_W-1:0] pop_slot,
  output logic              empty,
  input  logic              push,
  input  logic [SLOT_W-1:0] push_slot,
  input  logic              save,
  input  logic              restore
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SLOT_W-1:0] fl [DEPTH];
  logic [IW-1:0]     rd_idx, wr_idx, sv_idx;
  logic              rd_wrap, wr_wrap, sv_wrap;
  logic              full;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
    return (i == IW'(DEPTH-1)) ? '0 : i + IW'(1);
  endfunction

  assign empty    = (rd_idx == wr_idx) && (rd_wrap == wr_wrap);
  assign full     = (rd_idx == wr_idx) && (rd_wrap != wr_wrap);
  assign pop_slot = fl[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) fl[i] <= SLOT_W'(BASE + i);
      rd_idx  <= '0;
      rd_wrap <= 1'b0;
      wr_idx  <= '0;
      wr_wrap <= 1'b1;
      sv_idx  <= '0;
      sv_wrap <= 1'b0;
    end else begin
      if (save) begin
        sv_idx  <= rd_idx;
        sv_wrap <= rd_wrap;
      end
      if (restore) begin
        rd_idx  <= sv_idx;
        rd_wrap <= sv_wrap;
      end else if (pop) begin
        rd_idx <= nxt(rd_idx);
        if (rd_idx == IW'(DEPTH-1)) rd_wrap <= ~rd_wrap;
      end
      if (push) begin
        fl[wr_idx] <= push_slot;
        wr_idx     <= nxt(wr_idx);
        if (wr_idx == IW'(DEPTH-1)) wr_wrap <= ~wr_wrap;
      end
    end
  end

  // R6
  pop_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  // R8
  push_not_full_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
endmodule

// File: rtl/slot_ram.sv
module slot_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/slot_ingress.sv
module slot_ingress
  import slot_buf_pkg::*;
#(
  parameter int N_LOC      = 8,
  parameter int N_EXT      = 16,
  parameter int SLOT_WORDS = 128,
  parameter int PTR_W      = 5,
  parameter int WORD_W     = 8,
  parameter int LA_W       = 10,
  parameter int EA_W       = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [7:0]        in_tag,
  output logic              in_ready,
  output logic              loc_pop,
  input  logic [PTR_W-1:0]  loc_slot,
  input  logic              loc_empty,
  output logic              ext_pop,
  input  logic [PTR_W-1:0]  ext_slot,
  input  logic              ext_empty,
  output logic              save,
  output logic              restore,
  output logic              lwe,
  output logic [LA_W-1:0]   lwaddr,
  output logic              ewe,
  output logic [EA_W-1:0]   ewaddr,
  output logic [WORD_W-1:0] wdata,
  output logic              desc_valid,
  output logic [DESC_W-1:0] desc_data,
  output logic [DROP_W-1:0] drop_count
);
  localparam int SW_W = $clog2(SLOT_WORDS);
  localparam int LI_W = LA_W - SW_W;
  localparam int EI_W = EA_W - SW_W;

  ing_st_t          st;
  logic [PTR_W-1:0] cur, head, wr_slot;
  logic [SW_W-1:0]  widx, wr_word;
  logic [LEN_W-1:0] len;
  logic [7:0]       tag;
  logic             fin, wr_en, wr_local;

  assign in_ready = (st != IS_LINK);

  always_comb begin
    wr_en   = 1'b0;
    wr_slot = cur;
    wr_word = widx;
    wdata   = '0;
    loc_pop = 1'b0;
    ext_pop = 1'b0;
    save    = 1'b0;
    restore = 1'b0;
    unique case (st)
      IS_IDLE: if (in_valid && !loc_empty) begin
        loc_pop = 1'b1;
        save    = 1'b1;
        wr_en   = 1'b1;
        wr_slot = loc_slot;
        wr_word = '0;
        wdata   = WORD_W'(in_data);
      end
      IS_DATA: if (in_valid) begin
        wr_en = 1'b1;
        wdata = WORD_W'(in_data);
      end
      IS_LINK: begin
        wr_word = SW_W'(SLOT_WORDS-1);
        if (fin) begin
          wr_en = 1'b1;
        end else if (!ext_empty) begin
          ext_pop = 1'b1;
          wr_en   = 1'b1;
          wdata   = WORD_W'(ext_slot);
        end else begin
          restore = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign wr_local = (wr_slot <= PTR_W'(N_LOC));
  assign lwe      = wr_en && wr_local;
  assign ewe      = wr_en && !wr_local;
  assign lwaddr   = {LI_W'(wr_slot - PTR_W'(1)), wr_word};
  assign ewaddr   = {EI_W'(wr_slot - PTR_W'(N_LOC+1)), wr_word};

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= IS_IDLE;
      cur        <= '0;
      head       <= '0;
      widx       <= '0;
      len        <= '0;
      tag        <= '0;
      fin        <= 1'b0;
      desc_valid <= 1'b0;
      desc_data  <= '0;
      drop_count <= '0;
    end else begin
      desc_valid <= 1'b0;
      unique case (st)
        IS_IDLE: if (in_valid) begin
          if (loc_empty) begin
            drop_count <= drop_count + DROP_W'(1);
            st         <= in_last ? IS_IDLE : IS_DROP;
          end else begin
            cur  <= loc_slot;
            head <= loc_slot;
            tag  <= in_tag;
            len  <= LEN_W'(1);
            widx <= SW_W'(1);
            fin  <= in_last;
            st   <= in_last ? IS_LINK : IS_DATA;
          end
        end
        IS_DATA: if (in_valid) begin
          len <= len + LEN_W'(1);
          if (in_last) begin
            fin <= 1'b1;
            st  <= IS_LINK;
          end else if (widx == SW_W'(SLOT_WORDS-2)) begin
            fin <= 1'b0;
            st  <= IS_LINK;
          end else begin
            widx <= widx + SW_W'(1);
          end
        end
        IS_LINK: begin
          if (fin) begin
            desc_valid <= 1'b1;
            desc_data  <= '0;
            desc_data[HEAD_LSB +: HEAD_W] <= HEAD_W'(head);
            desc_data[LEN_LSB +: LEN_W]   <= len;
            desc_data[TAG_LSB +: TAG_W]   <= tag;
            st <= IS_IDLE;
          end else if (!ext_empty) begin
            cur  <= ext_slot;
            widx <= '0;
            st   <= IS_DATA;
          end else begin
            drop_count <= drop_count + DROP_W'(1);
            st         <= IS_DROP;
          end
        end
        IS_DROP: if (in_valid && in_last) st <= IS_IDLE;
        default: st <= IS_IDLE;
      endcase
    end
  end

  // R5
  last_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last && st == IS_DATA) |=> !in_ready);
  // R2
  desc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    desc_valid |=> !desc_valid);
  // R3
  head_local_chk: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> (desc_data[HEAD_LSB +: HEAD_W] != '0 &&
                    desc_data[HEAD_LSB +: HEAD_W] <= HEAD_W'(N_LOC)));
  // R6
  drop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + DROP_W'(1)));
endmodule

// File: rtl/slot_egress.sv
module slot_egress
  import slot_buf_pkg::*;
#(
  parameter int N_LOC      = 8,
  parameter int SLOT_WORDS = 128,
  parameter int PTR_W      = 5,
  parameter int WORD_W     = 8,
  parameter int LA_W       = 10,
  parameter int EA_W       = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_in_valid,
  input  logic [DESC_W-1:0] desc_in,
  output logic              eg_ready,
  output logic              lre,
  output logic [LA_W-1:0]   lraddr,
  input  logic [WORD_W-1:0] lrdata,
  output logic              ere,
  output logic [EA_W-1:0]   eraddr,
  input  logic [WORD_W-1:0] erdata,
  output logic              loc_push,
  output logic              ext_push,
  output logic [PTR_W-1:0]  push_slot,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last
);
  localparam int SW_W = $clog2(SLOT_WORDS);
  localparam int LI_W = LA_W - SW_W;
  localparam int EI_W = EA_W - SW_W;

  egr_st_t          st;
  logic [PTR_W-1:0] slot;
  logic [SW_W-1:0]  widx, rd_word;
  logic [LEN_W-1:0] rem;
  logic             rd_en, rd_local, push, p_v, p_last, p_sel;
  logic [WORD_W-1:0] q;
  logic              desc_unused;

  assign desc_unused = ^{desc_in[DESC_W-1:LEN_LSB+LEN_W], desc_in[HEAD_W-1:PTR_W]};

  assign eg_ready  = (st == ES_IDLE);
  assign rd_en     = (st == ES_RD) || (st == ES_PTR);
  assign rd_word   = (st == ES_PTR) ? SW_W'(SLOT_WORDS-1) : widx;
  assign rd_local  = (slot <= PTR_W'(N_LOC));
  assign lre       = rd_en && rd_local;
  assign ere       = rd_en && !rd_local;
  assign lraddr    = {LI_W'(slot - PTR_W'(1)), rd_word};
  assign eraddr    = {EI_W'(slot - PTR_W'(N_LOC+1)), rd_word};
  assign push      = ((st == ES_RD) && rem == LEN_W'(1)) || (st == ES_WAIT);
  assign push_slot = slot;
  assign loc_push  = push && rd_local;
  assign ext_push  = push && !rd_local;
  assign q         = p_sel ? lrdata : erdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ES_IDLE;
      slot      <= '0;
      widx      <= '0;
      rem       <= '0;
      p_v       <= 1'b0;
      p_last    <= 1'b0;
      p_sel     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      p_v       <= (st == ES_RD);
      p_last    <= (st == ES_RD) && rem == LEN_W'(1);
      if (rd_en) p_sel <= rd_local;
      out_valid <= p_v;
      out_data  <= q[7:0];
      out_last  <= p_v && p_last;
      unique case (st)
        ES_IDLE: if (desc_in_valid && desc_in[LEN_LSB +: LEN_W] != '0) begin
          slot <= desc_in[HEAD_LSB +: PTR_W];
          rem  <= desc_in[LEN_LSB +: LEN_W];
          widx <= '0;
          st   <= ES_RD;
        end
        ES_RD: begin
          rem <= rem - LEN_W'(1);
          if (rem == LEN_W'(1))                     st <= ES_IDLE;
          else if (widx == SW_W'(SLOT_WORDS-2))     st <= ES_PTR;
          else                                       widx <= widx + SW_W'(1);
        end
        ES_PTR: st <= ES_WAIT;
        ES_WAIT: begin
          slot <= q[PTR_W-1:0];
          widx <= '0;
          st   <= ES_RD;
        end
        default: st <= ES_IDLE;
      endcase
    end
  end

  // R4
  last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  // R3
  link_nonnull_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ES_WAIT) |-> (q[PTR_W-1:0] != '0));
  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (desc_in_valid && eg_ready && desc_in[LEN_LSB +: LEN_W] != '0) |=> !eg_ready);
endmodule

// File: rtl/slot_buffer_mgr.sv
module slot_buffer_mgr
  import slot_buf_pkg::*;
#(
  parameter int N_LOC      = 8,
  parameter int N_EXT      = 16,
  parameter int SLOT_WORDS = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  input  logic               in_last,
  input  logic [7:0]         in_tag,
  output logic               in_ready,
  output logic               desc_valid,
  output logic [127:0]       desc_data,
  output logic [15:0]        drop_count,
  input  logic               eg_desc_valid,
  input  logic [127:0]       eg_desc,
  output logic               eg_ready,
  output logic               out_valid,
  output logic [7:0]         out_data,
  output logic               out_last
);
  localparam int SLOT_CNT = N_LOC + N_EXT;
  localparam int PTR_W    = $clog2(SLOT_CNT + 1);
  localparam int WORD_W   = (PTR_W > 8) ? PTR_W : 8;
  localparam int SW_W     = $clog2(SLOT_WORDS);
  localparam int LA_W     = $clog2(N_LOC) + SW_W;
  localparam int EA_W     = $clog2(N_EXT) + SW_W;

  logic              loc_pop, loc_empty, loc_push;
  logic              ext_pop, ext_empty, ext_push;
  logic              save, restore;
  logic [PTR_W-1:0]  loc_slot, ext_slot, push_slot;
  logic              lwe, ewe, lre, ere;
  logic [LA_W-1:0]   lwaddr, lraddr;
  logic [EA_W-1:0]   ewaddr, eraddr;
  logic [WORD_W-1:0] wdata, lrdata, erdata;

  slot_free_list #(.DEPTH(N_LOC), .BASE(1), .SLOT_W(PTR_W)) i_loc_list (
    .clk(clk), .rst(rst), .pop(loc_pop), .pop_slot(loc_slot), .empty(loc_empty),
    .push(loc_push), .push_slot(push_slot), .save(save), .restore(restore));

  slot_free_list #(.DEPTH(N_EXT), .BASE(N_LOC+1), .SLOT_W(PTR_W)) i_ext_list (
    .clk(clk), .rst(rst), .pop(ext_pop), .pop_slot(ext_slot), .empty(ext_empty),
    .push(ext_push), .push_slot(push_slot), .save(save), .restore(restore));

  slot_ram #(.DEPTH(N_LOC*SLOT_WORDS), .WIDTH(WORD_W), .AW(LA_W)) i_loc_ram (
    .clk(clk), .we(lwe), .waddr(lwaddr), .wdata(wdata),
    .re(lre), .raddr(lraddr), .rdata(lrdata));

  slot_ram #(.DEPTH(N_EXT*SLOT_WORDS), .WIDTH(WORD_W), .AW(EA_W)) i_ext_ram (
    .clk(clk), .we(ewe), .waddr(ewaddr), .wdata(wdata),
    .re(ere), .raddr(eraddr), .rdata(erdata));

  slot_ingress #(.N_LOC(N_LOC), .N_EXT(N_EXT), .SLOT_WORDS(SLOT_WORDS), .PTR_W(PTR_W),
                 .WORD_W(WORD_W), .LA_W(LA_W), .EA_W(EA_W)) i_ingress (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_tag(in_tag), .in_ready(in_ready),
    .loc_pop(loc_pop), .loc_slot(loc_slot), .loc_empty(loc_empty),
    .ext_pop(ext_pop), .ext_slot(ext_slot), .ext_empty(ext_empty),
    .save(save), .restore(restore),
    .lwe(lwe), .lwaddr(lwaddr), .ewe(ewe), .ewaddr(ewaddr), .wdata(wdata),
    .desc_valid(desc_valid), .desc_data(desc_data), .drop_count(drop_count));

  slot_egress #(.N_LOC(N_LOC), .SLOT_WORDS(SLOT_WORDS), .PTR_W(PTR_W),
                .WORD_W(WORD_W), .LA_W(LA_W), .EA_W(EA_W)) i_egress (
    .clk(clk), .rst(rst), .desc_in_valid(eg_desc_valid), .desc_in(eg_desc),
    .eg_ready(eg_ready),
    .lre(lre), .lraddr(lraddr), .lrdata(lrdata),
    .ere(ere), .eraddr(eraddr), .erdata(erdata),
    .loc_push(loc_push), .ext_push(ext_push), .push_slot(push_slot),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last));
endmodule

// File: tb/test_slot_buffer_mgr.sv
module test_slot_buffer_mgr;
  localparam int LN = 4;
  localparam int EN = 6;
  localparam int SW = 4;
  localparam int D  = SW - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0, in_tag = '0;
  logic in_ready, desc_valid, eg_ready, out_valid, out_last;
  logic [127:0] desc_data;
  logic [15:0]  drop_count;
  logic eg_desc_valid = 1'b0;
  logic [127:0] eg_desc = '0;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  slot_buffer_mgr #(.N_LOC(LN), .N_EXT(EN), .SLOT_WORDS(SW)) i_slot_buffer_mgr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_tag(in_tag), .in_ready(in_ready), .desc_valid(desc_valid), .desc_data(desc_data),
    .drop_count(drop_count), .eg_desc_valid(eg_desc_valid), .eg_desc(eg_desc),
    .eg_ready(eg_ready), .out_valid(out_valid), .out_data(out_data), .out_last(out_last));

  int n_chk = 0, n_fail = 0;
  int desc_cnt = 0;
  logic [127:0] last_desc;
  int loc_free = LN, ext_free = EN;
  logic [127:0] o_desc [16];
  int o_len [16];
  int o_tag [16];
  int o_n = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int tag, input int k);
    return 8'(tag * 29 + k * 13 + 7);
  endfunction

  function automatic int need_ext(input int len);
    return (len + D - 1) / D - 1;
  endfunction

  always @(negedge clk) if (desc_valid) begin
    desc_cnt++;
    last_desc = desc_data;
  end

  task automatic send_pkt(input int len, input int tag);
    bit exp_drop;
    int cnt0, drop0, stalls;
    exp_drop = (loc_free == 0) || (ext_free < need_ext(len));
    cnt0 = desc_cnt;
    drop0 = int'(drop_count);
    stalls = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      while (!in_ready) begin stalls++; @(negedge clk); end
      in_valid = 1'b1;
      in_data  = pbyte(tag, k);
      in_last  = (k == len - 1);
      in_tag   = 8'(tag);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (!in_ready) stalls++;
      @(negedge clk);
    end
    if (exp_drop) begin
      chk(desc_cnt == cnt0, "R6/R7 no descriptor on drop", desc_cnt - cnt0, 0);
      chk(int'(drop_count) == drop0 + 1, "R6/R7 drop count", drop_count, drop0 + 1);
    end else begin
      chk(desc_cnt == cnt0 + 1, "R2 one descriptor", desc_cnt - cnt0, 1);
      chk(int'(last_desc[31:16]) == len, "R2 length field", last_desc[31:16], len);
      chk(int'(last_desc[39:32]) == (tag & 255), "R2 tag field", last_desc[39:32], tag & 255);
      chk(last_desc[127:40] == '0, "R2 reserved zero", 64'(last_desc[127:40] != '0), 0);
      chk(last_desc[15:0] >= 1 && last_desc[15:0] <= LN, "R3 head on-chip", last_desc[15:0], 1);
      for (int j = 0; j < o_n; j++)
        chk(o_desc[j][15:0] != last_desc[15:0], "R3 distinct heads", last_desc[15:0], o_desc[j][15:0]);
      chk(stalls == (len + D - 1) / D, "R5 stall cycles", stalls, (len + D - 1) / D);
      chk(int'(drop_count) == drop0, "R6 no drop", drop_count, drop0);
      loc_free--;
      ext_free -= need_ext(len);
      o_desc[o_n] = last_desc;
      o_len[o_n]  = len;
      o_tag[o_n]  = tag;
      o_n++;
    end
  endtask

  task automatic recv_pkt(input int idx, input bit poke);
    int len, tag, k, bad, c;
    bit seen_last;
    len = o_len[idx];
    tag = o_tag[idx];
    @(negedge clk);
    while (!eg_ready) @(negedge clk);
    eg_desc_valid = 1'b1;
    eg_desc = o_desc[idx];
    @(negedge clk);
    eg_desc_valid = 1'b0;
    chk(!eg_ready, "R9 busy after accept", eg_ready, 0);
    k = 0; bad = 0; c = 0; seen_last = 0;
    while (!seen_last && c < 400) begin
      if (poke && c == 0) begin
        eg_desc_valid = 1'b1;
        eg_desc = {88'd0, 8'd1, 16'd9, 16'd1};
      end else begin
        eg_desc_valid = 1'b0;
      end
      if (out_valid) begin
        if (out_data != pbyte(tag, k)) bad++;
        if (out_last != (k == len - 1)) bad++;
        if (out_last) seen_last = 1;
        k++;
      end
      @(negedge clk);
      c++;
    end
    eg_desc_valid = 1'b0;
    chk(bad == 0, "R4 data and end marker", bad, 0);
    chk(k == len, "R4 byte count", k, len);
    c = 0;
    for (int i = 0; i < 8; i++) begin
      if (out_valid) c++;
      @(negedge clk);
    end
    chk(c == 0, poke ? "R9 ignored descriptor" : "R4 no extra bytes", c, 0);
    loc_free++;
    ext_free += need_ext(len);
    o_n--;
    o_desc[idx] = o_desc[o_n];
    o_len[idx]  = o_len[o_n];
    o_tag[idx]  = o_tag[o_n];
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(eg_ready == 1'b1, "R1 eg_ready", eg_ready, 1);
    chk(desc_valid == 1'b0, "R1 desc_valid", desc_valid, 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(drop_count == 16'd0, "R1 drop_count", drop_count, 0);

    // single and boundary lengths
    send_pkt(1, 11);  recv_pkt(0, 0);
    send_pkt(3, 12);  recv_pkt(0, 0);
    send_pkt(4, 13);  recv_pkt(0, 1);
    send_pkt(21, 14); recv_pkt(0, 0);

    // R7 external pool exhausted mid-packet, slots returned
    send_pkt(22, 15);
    send_pkt(21, 16); recv_pkt(0, 0);

    // R6 / R8 on-chip pool exhaustion and refill
    for (int i = 0; i < LN; i++) send_pkt(2, 20 + i);
    send_pkt(2, 30);
    recv_pkt(1, 0);
    send_pkt(5, 31);
    while (o_n > 0) recv_pkt(o_n - 1, 0);

    // R7 partial external availability
    send_pkt(12, 40);
    send_pkt(15, 41);
    send_pkt(12, 42);
    recv_pkt(1, 0);
    recv_pkt(0, 0);
    chk(loc_free == LN && ext_free == EN, "R8 model pools full", loc_free, LN);

    // random mix
    for (int it = 0; it < 300; it++) begin
      if (o_n > 0 && (($urandom % 3) == 0 || o_n >= 6))
        recv_pkt(int'($urandom % o_n), ($urandom % 5) == 0);
      else
        send_pkt(1 + int'($urandom % 24), int'($urandom % 256));
    end
    while (o_n > 0) recv_pkt(0, 0);
    // R8 full capacity again after all reads
    send_pkt(21, 99);
    recv_pkt(0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule